// File: doc/BRIEF.md
# Segmented Integer Prefix-Sum Unit

This unit takes one vector register of integer data and returns the running sum of its elements, lane by lane. Each element's output is the total of every element before it and itself. A second vector operand carries a segment identifier per element. Wherever that identifier changes from one element to the next, the running sum starts again from zero. The last element of each segment therefore holds that segment's total. This makes the unit the reduce stage for bags of embedding rows, where one register holds the rows of several samples. No setup instruction and no side register are needed to describe the boundaries.

A 6-bit opcode selects the variant. The unsegmented 32-bit scan ignores the identifiers. The segmented 32-bit scan honours them. The segmented 16-bit scan packs two elements per 32-bit lane and keeps 16-bit sums. The widening scan sign-extends 16-bit elements into 32-bit partial sums. A per-element predicate mask removes elements from the sum. A 3-bit seed select can continue the running sum from the previous scan, so a segment can span several registers. Results appear one clock after issue.

Top module: `segscan_unit`

## Requirements
- R1: With opcode 10 (segmented, 32-bit elements), lane i (bits [32i+31:32i] of data and id) outputs the sum, modulo 2^32, of all enabled elements of its segment from the segment start up to and including lane i.
- R2: A segment starts at element 0 (unless carried in per R7) and at every element whose identifier differs from the identifier of the element below it. The running sum restarts at 0 there.
- R3: With opcode 5 (unsegmented, 32-bit), the identifier vector has no effect, and the whole vector is one segment.
- R4: With opcode 11 (segmented 16-bit), there are 2*LANES elements. Element e is bits [16e+15:16e] of data and of the identifier vector, and result element e sits at the same position with its sum wrapped modulo 2^16.
- R5: With opcode 12 (widening), elements 0..LANES-1 of the 16-bit packed data are sign-extended and summed. Element e's 32-bit sum goes to result lane e, and its identifier is bits [16e+15:16e].
- R6: Mask bit e controls element e in every mode. A masked element adds 0 and outputs the running value. A boundary on a masked element still restarts the sum, so its output is 0.
- R7: With seed select 1, element 0 continues from the final sum of the last supported scan since reset. For opcodes 10, 11 and 12 this holds only when element 0's identifier (zero-extended) equals that scan's final identifier; for opcode 5 it always holds. Seed select 0 and values 2..7 start from 0.
- R8: Any other opcode (including 15) gives an all-zero result and leaves the carried sum and identifier unchanged.
- R9: out_valid rises exactly one cycle after in_valid. Without an issue, out_valid is 0 and the result holds. After reset, out_valid and result are 0 and no carry is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue one scan this cycle |
| opcode | input | 6 | Variant select (5, 10, 11, 12) |
| seed_sel | input | 3 | 0 identity, 1 continue previous scan |
| data_vec | input | 32*LANES | Data operand |
| seg_vec | input | 32*LANES | Segment identifier operand |
| mask | input | 2*LANES | Per-element enable, bit e for element e |
| out_valid | output | 1 | Result valid |
| result | output | 32*LANES | Per-element running sums |

## Verification
Two events can land on the same element: a carried-in sum from the previous scan and a segment restart at element 0. A restart can also fall on an element that the mask disables. The bench provokes the first case by chaining scans under seed select 1, with the first identifier either matching or differing from the previous final identifier. It provokes the second by placing mask gaps exactly on identifier changes. Each result is judged against hand-derived vectors and against an arithmetic model kept in the bench, across sweeps of mixed opcodes, identifiers and masks.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    localparam logic [5:0] OPC_PLAIN_S32 = 6'd5;
    localparam logic [5:0] OPC_SEG_S32   = 6'd10;
    localparam logic [5:0] OPC_SEG_S16   = 6'd11;
    localparam logic [5:0] OPC_SEG_S16W  = 6'd12;

    localparam logic [2:0] SEED_IDENTITY = 3'd0;
    localparam logic [2:0] SEED_CARRY    = 3'd1;

    typedef enum logic [2:0] {
        MODE_NONE    = 3'd0,
        MODE_PLAIN32 = 3'd1,
        MODE_SEG32   = 3'd2,
        MODE_SEG16   = 3'd3,
        MODE_WIDE16  = 3'd4
    } scan_mode_e;

    typedef struct packed {
        logic [31:0] acc;
        logic [31:0] id;
        logic        valid;
    } carry_t;

endpackage

// File: rtl/segscan_decode.sv
module segscan_decode
    import segscan_pkg::*;
(
    input  logic [5:0]  opcode,
    output scan_mode_e  mode,
    output logic        segmented
);

    always_comb begin
        mode      = MODE_NONE;
        segmented = 1'b0;
        case (opcode)
            OPC_PLAIN_S32: mode = MODE_PLAIN32;
            OPC_SEG_S32: begin
                mode      = MODE_SEG32;
                segmented = 1'b1;
            end
            OPC_SEG_S16: begin
                mode      = MODE_SEG16;
                segmented = 1'b1;
            end
            OPC_SEG_S16W: begin
                mode      = MODE_WIDE16;
                segmented = 1'b1;
            end
            default: begin
                mode      = MODE_NONE;
                segmented = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/segscan_unpack.sv
module segscan_unpack
    import segscan_pkg::*;
#(
    parameter int LANES = 8,
    localparam int ELEMS = 2 * LANES,
    localparam int VW    = 32 * LANES
) (
    input  scan_mode_e             mode,
    input  logic [VW-1:0]          data_vec,
    input  logic [VW-1:0]          seg_vec,
    input  logic [ELEMS-1:0]       mask,
    output logic [ELEMS-1:0][31:0] val,
    output logic [ELEMS-1:0][31:0] id,
    output logic [ELEMS-1:0]       en,
    output logic [ELEMS-1:0]       live
);

    logic [ELEMS-1:0][31:0] val_w32, id_w32, val_w16, id_w16;

    always_comb begin
        val_w32 = '0;
        id_w32  = '0;
        for (int i = 0; i < LANES; i++) begin
            val_w32[i] = data_vec[32*i +: 32];
            id_w32[i]  = seg_vec[32*i +: 32];
        end
        for (int e = 0; e < ELEMS; e++) begin
            val_w16[e] = {{16{data_vec[16*e+15]}}, data_vec[16*e +: 16]};
            id_w16[e]  = {16'h0000, seg_vec[16*e +: 16]};
        end
    end

    always_comb begin
        val  = '0;
        id   = '0;
        en   = '0;
        live = '0;
        for (int e = 0; e < ELEMS; e++) begin
            case (mode)
                MODE_PLAIN32, MODE_SEG32: begin
                    if (e < LANES) begin
                        val[e]  = val_w32[e];
                        id[e]   = id_w32[e];
                        en[e]   = mask[e];
                        live[e] = 1'b1;
                    end
                end
                MODE_SEG16: begin
                    val[e]  = val_w16[e];
                    id[e]   = id_w16[e];
                    en[e]   = mask[e];
                    live[e] = 1'b1;
                end
                MODE_WIDE16: begin
                    if (e < LANES) begin
                        val[e]  = val_w16[e];
                        id[e]   = id_w16[e];
                        en[e]   = mask[e];
                        live[e] = 1'b1;
                    end
                end
                default: begin
                    val[e]  = '0;
                    id[e]   = '0;
                    en[e]   = 1'b0;
                    live[e] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/segscan_chain.sv
module segscan_chain #(
    parameter int LANES = 8,
    localparam int ELEMS = 2 * LANES
) (
    input  logic [ELEMS-1:0][31:0] val,
    input  logic [ELEMS-1:0][31:0] id,
    input  logic [ELEMS-1:0]       en,
    input  logic [ELEMS-1:0]       live,
    input  logic                   segmented,
    input  logic                   cont_in,
    input  logic [31:0]            carry_acc,
    output logic [ELEMS-1:0][31:0] acc,
    output logic [31:0]            last_acc,
    output logic [31:0]            last_id
);

    logic [ELEMS-1:0]       restart;
    logic [ELEMS-1:0][31:0] base;
    logic [ELEMS-1:0][31:0] addend;
    logic [ELEMS-1:0]       tail;

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        if (e == 0) begin : g_first
            assign restart[e] = !cont_in;
            assign base[e]    = restart[e] ? 32'd0 : carry_acc;
        end else begin : g_rest
            assign restart[e] = segmented && (id[e] != id[e-1]);
            assign base[e]    = restart[e] ? 32'd0 : acc[e-1];
        end

        if (e == ELEMS - 1) begin : g_top
            assign tail[e] = live[e];
        end else begin : g_mid
            assign tail[e] = live[e] && !live[e+1];
        end

        assign addend[e] = en[e] ? val[e] : 32'd0;
        assign acc[e]    = base[e] + addend[e];
    end

    always_comb begin
        last_acc = '0;
        last_id  = '0;
        for (int e = 0; e < ELEMS; e++) begin
            if (tail[e]) begin
                last_acc = acc[e];
                last_id  = id[e];
            end
        end
    end

endmodule

// File: rtl/segscan_pack.sv
module segscan_pack
    import segscan_pkg::*;
#(
    parameter int LANES = 8,
    localparam int ELEMS = 2 * LANES,
    localparam int VW    = 32 * LANES
) (
    input  scan_mode_e             mode,
    input  logic [ELEMS-1:0][31:0] acc,
    output logic [VW-1:0]          packed_vec
);

    logic [VW-1:0] wide_vec, narrow_vec;

    always_comb begin
        wide_vec   = '0;
        narrow_vec = '0;
        for (int i = 0; i < LANES; i++) begin
            wide_vec[32*i +: 32] = acc[i];
        end
        for (int e = 0; e < ELEMS; e++) begin
            narrow_vec[16*e +: 16] = acc[e][15:0];
        end
    end

    always_comb begin
        case (mode)
            MODE_PLAIN32, MODE_SEG32, MODE_WIDE16: packed_vec = wide_vec;
            MODE_SEG16:                            packed_vec = narrow_vec;
            default:                               packed_vec = '0;
        endcase
    end

endmodule

// File: rtl/segscan_unit.sv
module segscan_unit
    import segscan_pkg::*;
#(
    parameter int LANES = 8,
    localparam int ELEMS = 2 * LANES,
    localparam int VW    = 32 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       opcode,
    input  logic [2:0]       seed_sel,
    input  logic [VW-1:0]    data_vec,
    input  logic [VW-1:0]    seg_vec,
    input  logic [ELEMS-1:0] mask,
    output logic             out_valid,
    output logic [VW-1:0]    result
);

    typedef struct packed {
        logic          out_valid;
        logic [VW-1:0] result;
        carry_t        carry;
    } state_t;

    state_t state_d, state_q;

    scan_mode_e             mode;
    logic                   segmented;
    logic [ELEMS-1:0][31:0] val, id, acc;
    logic [ELEMS-1:0]       en, live;
    logic                   cont_in;
    logic [31:0]            last_acc, last_id;
    logic [VW-1:0]          packed_vec;

    segscan_decode i_decode (
        .opcode    (opcode),
        .mode      (mode),
        .segmented (segmented)
    );

    segscan_unpack #(.LANES(LANES)) i_unpack (
        .mode     (mode),
        .data_vec (data_vec),
        .seg_vec  (seg_vec),
        .mask     (mask),
        .val      (val),
        .id       (id),
        .en       (en),
        .live     (live)
    );

    always_comb begin
        cont_in = (seed_sel == SEED_CARRY) && state_q.carry.valid
                  && (!segmented || (id[0] == state_q.carry.id));
    end

    segscan_chain #(.LANES(LANES)) i_chain (
        .val       (val),
        .id        (id),
        .en        (en),
        .live      (live),
        .segmented (segmented),
        .cont_in   (cont_in),
        .carry_acc (state_q.carry.acc),
        .acc       (acc),
        .last_acc  (last_acc),
        .last_id   (last_id)
    );

    segscan_pack #(.LANES(LANES)) i_pack (
        .mode       (mode),
        .acc        (acc),
        .packed_vec (packed_vec)
    );

    always_comb begin
        state_d           = state_q;
        state_d.out_valid = in_valid;
        if (in_valid) begin
            if (mode == MODE_NONE) begin
                state_d.result = '0;
            end else begin
                state_d.result      = packed_vec;
                state_d.carry.acc   = last_acc;
                state_d.carry.id    = last_id;
                state_d.carry.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.out_valid;
    assign result    = state_q.result;

endmodule

// File: rtl/segscan_checks.sv
module segscan_checks
    import segscan_pkg::*;
#(
    parameter int LANES = 8,
    localparam int ELEMS = 2 * LANES,
    localparam int VW    = 32 * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [5:0]       opcode,
    input logic [2:0]       seed_sel,
    input logic [VW-1:0]    data_vec,
    input logic [ELEMS-1:0] mask,
    input logic             out_valid,
    input logic [VW-1:0]    result
);

    logic supported;
    assign supported = (opcode == OPC_PLAIN_S32) || (opcode == OPC_SEG_S32)
                    || (opcode == OPC_SEG_S16) || (opcode == OPC_SEG_S16W);

    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                         // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));                  // R9

    AST_BAD_OPCODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !supported) |=> (result == '0));                    // R8

    AST_SEED_IDENTITY_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seed_sel == SEED_IDENTITY && opcode == OPC_SEG_S32)
        |=> (result[31:0] == ($past(mask[0]) ? $past(data_vec[31:0]) : 32'd0))); // R7

    AST_WIDEN_SIGN_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seed_sel == SEED_IDENTITY && opcode == OPC_SEG_S16W)
        |=> (result[31:0] == ($past(mask[0])
            ? {{16{$past(data_vec[15])}}, $past(data_vec[15:0])} : 32'd0))); // R5

endmodule

bind segscan_unit segscan_checks #(.LANES(LANES)) i_segscan_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .seed_sel  (seed_sel),
    .data_vec  (data_vec),
    .mask      (mask),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_segscan_unit.sv
`timescale 1ns/1ps
module test_segscan_unit;

    localparam int L  = 4;
    localparam int NE = 2 * L;
    localparam int W  = 32 * L;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [5:0]    opcode = '0;
    logic [2:0]    seed_sel = '0;
    logic [W-1:0]  data_vec = '0;
    logic [W-1:0]  seg_vec = '0;
    logic [NE-1:0] mask = '0;
    logic          out_valid;
    logic [W-1:0]  result;

    int checks = 0;
    int errors = 0;

    logic          m_valid = 1'b0;
    logic [31:0]   m_acc = '0;
    logic [31:0]   m_id = '0;
    logic [W-1:0]  exp_model;
    logic [31:0]   rng = 32'h1234_5678;

    always #4 clk = ~clk;

    segscan_unit #(.LANES(L)) i_segscan_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .seed_sel(seed_sel), .data_vec(data_vec), .seg_vec(seg_vec),
        .mask(mask), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    task automatic run_model(input logic [5:0] op, input logic [2:0] sd,
                             input logic [W-1:0] d, input logic [W-1:0] s,
                             input logic [NE-1:0] m);
        int n;
        bit in16, out16, segd, ok, cont;
        logic [31:0] acc, v, idv, prev_id;
        exp_model = '0;
        ok = 1; in16 = 0; out16 = 0; segd = 1; n = L;
        case (op)
            6'd5:  segd = 0;
            6'd10: ;
            6'd11: begin in16 = 1; out16 = 1; n = NE; end
            6'd12: in16 = 1;
            default: ok = 0;
        endcase
        if (!ok) return;
        acc = m_acc;
        prev_id = '0;
        for (int e = 0; e < n; e++) begin
            if (in16) begin
                v   = {{16{d[16*e+15]}}, d[16*e +: 16]};
                idv = {16'h0, s[16*e +: 16]};
            end else begin
                v   = d[32*e +: 32];
                idv = s[32*e +: 32];
            end
            if (e == 0) begin
                cont = (sd == 3'd1) && m_valid && (!segd || idv == m_id);
                if (!cont) acc = 0;
            end else if (segd && idv != prev_id) begin
                acc = 0;
            end
            if (m[e]) acc = acc + v;
            if (out16) exp_model[16*e +: 16] = acc[15:0];
            else       exp_model[32*e +: 32] = acc;
            prev_id = idv;
        end
        m_acc = acc;
        m_id = prev_id;
        m_valid = 1'b1;
    endtask

    task automatic issue(input logic [5:0] op, input logic [2:0] sd,
                         input logic [W-1:0] d, input logic [W-1:0] s,
                         input logic [NE-1:0] m);
        @(negedge clk);
        opcode = op; seed_sel = sd; data_vec = d; seg_vec = s; mask = m;
        in_valid = 1'b1;
        run_model(op, sd, d, s, m);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R9 out_valid actual=%b expected=1", out_valid);
        end
    endtask

    function automatic logic [W-1:0] v32(input logic [31:0] a, b, c, e);
        return {e, c, b, a};
    endfunction

    function automatic logic [W-1:0] v16(input logic [15:0] a0, a1, a2, a3, a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        check("R9 reset result", result, '0);
        check("R9 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
        rst_n = 1'b1;

        // R1 one segment, all enabled
        issue(6'd10, 3'd0, v32(1, 2, 3, 4), v32(7, 7, 7, 7), 8'hFF);
        check("R1 single segment", result, v32(1, 3, 6, 10));
        // R2 boundary between lane 1 and lane 2
        issue(6'd10, 3'd0, v32(1, 2, 3, 4), v32(0, 0, 1, 1), 8'hFF);
        check("R2 boundary", result, v32(1, 3, 3, 7));
        // R9 hold while idle
        held = result;
        @(negedge clk); @(negedge clk);
        check("R9 idle hold", result, held);
        check("R9 idle valid", {{(W-1){1'b0}}, out_valid}, '0);
        // R7 carry continues (prev final acc 7, id 1)
        issue(6'd10, 3'd1, v32(5, 1, 1, 1), v32(1, 1, 2, 2), 8'hFF);
        check("R7 carry continue", result, v32(12, 13, 1, 2));
        // R7 carry refused: id differs from final id 2
        issue(6'd10, 3'd1, v32(5, 1, 1, 1), v32(3, 3, 3, 3), 8'hFF);
        check("R7 carry id mismatch", result, v32(5, 6, 7, 8));
        // R7 seed 2 means identity
        issue(6'd10, 3'd2, v32(5, 1, 1, 1), v32(3, 3, 3, 3), 8'hFF);
        check("R7 seed2 identity", result, v32(5, 6, 7, 8));
        // R8 unsupported opcode: zero, carry state kept (acc 8, id 3)
        issue(6'd15, 3'd1, v32(9, 9, 9, 9), v32(0, 0, 0, 0), 8'hFF);
        check("R8 unsupported zero", result, '0);
        issue(6'd10, 3'd1, v32(1, 1, 1, 1), v32(3, 3, 3, 3), 8'hFF);
        check("R8 carry untouched", result, v32(9, 10, 11, 12));
        // R6 masked lanes pass the running value
        issue(6'd10, 3'd0, v32(1, 2, 3, 4), v32(0, 0, 0, 0), 8'b1010);
        check("R6 masked pass", result, v32(0, 2, 2, 6));
        // R6 masked lane on a boundary outputs 0
        issue(6'd10, 3'd0, v32(1, 2, 3, 4), v32(0, 1, 1, 1), 8'b1101);
        check("R6 masked boundary", result, v32(1, 0, 3, 7));
        // R3 identifiers ignored in plain mode
        issue(6'd5, 3'd0, v32(1, 2, 3, 4), v32(0, 1, 2, 3), 8'hFF);
        check("R3 plain ignores ids", result, v32(1, 3, 6, 10));
        // R3 plain carry always continues
        issue(6'd5, 3'd1, v32(1, 1, 1, 1), v32(9, 8, 7, 6), 8'hFF);
        check("R3 plain carry", result, v32(11, 12, 13, 14));
        // R4 16-bit wrap and boundary at element 4
        issue(6'd11, 3'd0, v16(16'h7fff, 1, 5, 16'hffff, 2, 2, 2, 2),
              v16(0, 0, 0, 0, 1, 1, 1, 1), 8'hFF);
        check("R4 s16 wrap", result, v16(16'h7fff, 16'h8000, 16'h8005, 16'h8004, 2, 4, 6, 8));
        // R5 widening with sign extension
        issue(6'd12, 3'd0, v16(16'hffff, 3, 16'h8000, 1, 7, 7, 7, 7),
              v16(0, 0, 0, 0, 0, 0, 0, 0), 8'hFF);
        check("R5 widen sext", result, v32(32'hffffffff, 32'h2, 32'hffff8002, 32'hffff8003));

        // Sweep: all opcodes, seeds, masks, sparse identifier changes
        for (int it = 0; it < 3000; it++) begin
            logic [W-1:0] d, s;
            logic [5:0] op;
            logic [2:0] sd;
            logic [NE-1:0] m;
            for (int k = 0; k < L; k++) begin
                rng = next_rng(rng);
                d[32*k +: 32] = rng;
            end
            for (int k = 0; k < NE; k++) begin
                rng = next_rng(rng);
                s[16*k +: 16] = {15'h0, rng[0] & rng[1]};
            end
            rng = next_rng(rng);
            m = rng[7:0] | rng[15:8];
            case (rng[18:16])
                3'd0: op = 6'd5;
                3'd1: op = 6'd10;
                3'd2: op = 6'd11;
                3'd3: op = 6'd12;
                3'd4: op = 6'd15;
                3'd5: op = 6'd0;
                default: op = 6'd10;
            endcase
            sd = (rng[21:20] == 2'd3) ? 3'd5 : {1'b0, rng[21:20]};
            issue(op, sd, d, s, m);
            case (op)
                6'd5:  check("R3 sweep plain", result, exp_model);
                6'd10: check("R1 R2 R6 R7 sweep seg32", result, exp_model);
                6'd11: check("R4 sweep s16", result, exp_model);
                6'd12: check("R5 sweep widen", result, exp_model);
                default: check("R8 sweep unsupported", result, exp_model);
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule